// File: doc/BRIEF.md
# Page-Level Sequential Coherence Directory

This block keeps caches coherent at page granularity for a small group of processors. It holds one status word for each shared page. The word is in one of two forms: a bit-vector of the processors that may read the page, or the encoded number of the single processor that may write it. From that word the block derives each processor's protection for the page: none, read, or write.

A processor that touches a page beyond its protection raises a read fault or a write fault, giving its processor number and the page index. The block works out the new protection of every processor. It then sends remote requests to the processors that must give up access and waits for all of them to acknowledge. A request either invalidates the cached lines and drops access, or downgrades a writer to reader. In write-back mode, a request to the current writer also asks it to flush its dirty lines. Once every acknowledge is in, the block updates the status word and grants the faulting processor its new access.

The block handles one fault at a time. Page tables, the interconnect and the caches sit outside the block and are reached only through the request/acknowledge ports. After reset the block spends one cycle per page clearing the status store, and only then accepts faults.

Top module: `page_coh_dir`

## Requirements
- R1: After reset, `flt_ready` stays low while the status store is cleared (one cycle per page) and then rises. At that point every processor holds no access to any page, so a first read fault on any page is granted read (`gnt_prot`=1) with no remote request. The protection encoding is none=0, read=1, write=2.
- R2: A read fault on a page that another processor holds for writing raises `rmt_req` for that writer alone, with `rmt_op`=1 (downgrade to read). The fault is then granted read, and the former writer keeps read access.
- R3: A write fault raises `rmt_req` for every other processor that holds read or write access, with `rmt_op`=0 (invalidate and drop access). The fault is then granted write (`gnt_prot`=2).
- R4: A page has at most one writer at a time. After a write grant every other processor holds no access, so a later write fault by a third processor targets only the current writer.
- R5: While a page has no writer, any number of processors may hold read access at once. A read fault then needs no remote request.
- R6: With write-back enabled (the default), `rmt_flush` is 1 on a request sent to the current writer of the page and 0 on a request sent to readers.
- R7: Each bit of `rmt_req` stays high until the matching bit of `rmt_ack` is seen, and the acknowledges may come in any order. `gnt_valid` pulses in the cycle after the last acknowledge is seen, and never while any `rmt_req` bit is high.
- R8: Faults are serialized. `flt_ready` is low from the cycle after a fault is accepted until the grant, `gnt_valid` is a single-cycle pulse, and `flt_ready` is high again in the cycle after it.
- R9: A fault from a processor that already holds the requested access or a higher one completes with no remote request. It is granted the access it already holds, so a read fault by the writer is granted write.
- R10: `gnt_cpu` and `gnt_page` echo the fault, and `rmt_page` carries the fault's page. Pages are tracked independently, including the first and last page index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | A fault request is offered |
| flt_ready | output | 1 | The block can accept a fault |
| flt_write | input | 1 | 1 = write fault, 0 = read fault |
| flt_cpu | input | IDW | Processor number of the faulting processor |
| flt_page | input | PW | Page index of the fault |
| rmt_req | output | NPROC | Per-processor remote request, held until acknowledged |
| rmt_op | output | 1 | 0 = invalidate and drop access, 1 = downgrade to read |
| rmt_flush | output | 1 | The target must flush its dirty lines first |
| rmt_page | output | PW | Page index of the remote request |
| rmt_ack | input | NPROC | Per-processor acknowledge of the remote request |
| gnt_valid | output | 1 | One-cycle grant pulse |
| gnt_cpu | output | IDW | Processor receiving the grant |
| gnt_page | output | PW | Page of the grant |
| gnt_prot | output | 2 | Granted protection: 0 none, 1 read, 2 write |

## Verification
The cycle that retires the last outstanding remote acknowledge is also the cycle that writes the status word and raises the grant. Acknowledges from several processors can land together or apart. The bench's responder acknowledges two targets with equal delays, so both retire in the same cycle, and later with unequal delays, so the later processor answers last. At every grant the scoreboard requires that an acknowledge was still being driven at the preceding edge and that no request bit remains high. Each following fault on the same page then shows whether the updated status word took effect.

// File: rtl/cohdir_pkg.sv
package cohdir_pkg;

  typedef enum logic [1:0] {
    PROT_NIL = 2'd0,
    PROT_RD  = 2'd1,
    PROT_WR  = 2'd2
  } prot_e;

  typedef enum logic [1:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOOK,
    ST_WAIT
  } dir_st_e;

  localparam logic OP_INVAL  = 1'b0;
  localparam logic OP_DGRADE = 1'b1;

endpackage

// File: rtl/cohdir_stat_ram.sv
module cohdir_stat_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port store with a registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cohdir_next.sv
module cohdir_next
  import cohdir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int IDW   = 2,
  parameter int SW    = 5,
  parameter bit WB_EN = 1'b1
) (
  input  logic [SW-1:0]    cur,
  input  logic [IDW-1:0]   cpu,
  input  logic             is_wr,
  output prot_e            gprot,
  output logic [NPROC-1:0] tgt,
  output logic             op,
  output logic             flush,
  output logic [SW-1:0]    nstat
);

  logic             wmode;
  logic [NPROC-1:0] cs;
  logic [IDW-1:0]   wid;
  logic [NPROC-1:0] me;
  logic [NPROC-1:0] wr_oh;
  prot_e            held;

  always_comb begin
    wmode = cur[SW-1];
    cs    = cur[NPROC-1:0];
    wid   = cur[IDW-1:0];
    me    = NPROC'(1) << cpu;
    wr_oh = NPROC'(1) << wid;
    if (wmode) held = (wid == cpu) ? PROT_WR : PROT_NIL;
    else       held = cs[cpu] ? PROT_RD : PROT_NIL;

    // default: the faulting processor already has enough access
    gprot = held;
    tgt   = '0;
    op    = OP_INVAL;
    flush = 1'b0;
    nstat = cur;

    if (is_wr) begin
      if (held != PROT_WR) begin
        gprot = PROT_WR;
        tgt   = (wmode ? wr_oh : cs) & ~me;
        flush = WB_EN && wmode;
        nstat = {1'b1, NPROC'(cpu)};
      end
    end else if (held == PROT_NIL) begin
      gprot = PROT_RD;
      op    = OP_DGRADE;
      if (wmode) begin
        tgt   = wr_oh;
        flush = WB_EN;
        nstat = {1'b0, wr_oh | me};
      end else begin
        nstat = {1'b0, cs | me};
      end
    end
  end

endmodule

// File: rtl/page_coh_dir.sv
module page_coh_dir
  import cohdir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NPAGE = 16,
  parameter bit WB_EN = 1'b1,
  localparam int IDW  = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int PW   = (NPAGE > 1) ? $clog2(NPAGE) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flt_valid,
  output logic             flt_ready,
  input  logic             flt_write,
  input  logic [IDW-1:0]   flt_cpu,
  input  logic [PW-1:0]    flt_page,
  output logic [NPROC-1:0] rmt_req,
  output logic             rmt_op,
  output logic             rmt_flush,
  output logic [PW-1:0]    rmt_page,
  input  logic [NPROC-1:0] rmt_ack,
  output logic             gnt_valid,
  output logic [IDW-1:0]   gnt_cpu,
  output logic [PW-1:0]    gnt_page,
  output logic [1:0]       gnt_prot
);

  localparam int SW = NPROC + 1;

  dir_st_e          st;
  logic [PW-1:0]    init_ptr;
  logic [IDW-1:0]   f_cpu;
  logic [PW-1:0]    f_page;
  logic             f_wr;
  logic [SW-1:0]    rd_stat;
  logic [SW-1:0]    nxt_q;
  prot_e            gprot_q;

  prot_e            nx_gprot;
  logic [NPROC-1:0] nx_tgt;
  logic             nx_op;
  logic             nx_flush;
  logic [SW-1:0]    nx_stat;

  logic             ram_we;
  logic [PW-1:0]    ram_waddr;
  logic [SW-1:0]    ram_wdata;
  logic             acks_done;

  assign flt_ready = (st == ST_IDLE);
  assign acks_done = ((rmt_req & ~rmt_ack) == '0);

  cohdir_stat_ram #(.DEPTH(NPAGE), .AW(PW), .DW(SW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (flt_page),
    .rdata (rd_stat)
  );

  cohdir_next #(.NPROC(NPROC), .IDW(IDW), .SW(SW), .WB_EN(WB_EN)) u_next (
    .cur   (rd_stat),
    .cpu   (f_cpu),
    .is_wr (f_wr),
    .gprot (nx_gprot),
    .tgt   (nx_tgt),
    .op    (nx_op),
    .flush (nx_flush),
    .nstat (nx_stat)
  );

  // status store write: clear sweep, immediate commit, or commit after acks
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = f_page;
    ram_wdata = nxt_q;
    unique case (st)
      ST_INIT: begin
        ram_we    = 1'b1;
        ram_waddr = init_ptr;
        ram_wdata = '0;
      end
      ST_LOOK: begin
        ram_we    = (nx_tgt == '0);
        ram_wdata = nx_stat;
      end
      ST_WAIT: ram_we = acks_done;
      default: ram_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_INIT;
      init_ptr  <= '0;
      f_cpu     <= '0;
      f_page    <= '0;
      f_wr      <= 1'b0;
      nxt_q     <= '0;
      gprot_q   <= PROT_NIL;
      rmt_req   <= '0;
      rmt_op    <= 1'b0;
      rmt_flush <= 1'b0;
      rmt_page  <= '0;
      gnt_valid <= 1'b0;
      gnt_cpu   <= '0;
      gnt_page  <= '0;
      gnt_prot  <= PROT_NIL;
    end else begin
      gnt_valid <= 1'b0;
      unique case (st)
        ST_INIT: begin
          init_ptr <= init_ptr + 1'b1;
          if (init_ptr == PW'(NPAGE - 1)) st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (flt_valid) begin
            f_cpu  <= flt_cpu;
            f_page <= flt_page;
            f_wr   <= flt_write;
            st     <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          nxt_q   <= nx_stat;
          gprot_q <= nx_gprot;
          if (nx_tgt == '0) begin
            gnt_valid <= 1'b1;
            gnt_cpu   <= f_cpu;
            gnt_page  <= f_page;
            gnt_prot  <= nx_gprot;
            st        <= ST_IDLE;
          end else begin
            rmt_req   <= nx_tgt;
            rmt_op    <= nx_op;
            rmt_flush <= nx_flush;
            rmt_page  <= f_page;
            st        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          rmt_req <= rmt_req & ~rmt_ack;
          if (acks_done) begin
            rmt_op    <= 1'b0;
            rmt_flush <= 1'b0;
            gnt_valid <= 1'b1;
            gnt_cpu   <= f_cpu;
            gnt_page  <= f_page;
            gnt_prot  <= gprot_q;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/page_coh_dir_chk.sv
module page_coh_dir_chk #(
  parameter int NPROC = 4,
  parameter int PW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             flt_ready,
  input logic [NPROC-1:0] rmt_req,
  input logic             rmt_op,
  input logic             rmt_flush,
  input logic [PW-1:0]    rmt_page,
  input logic [NPROC-1:0] rmt_ack,
  input logic             gnt_valid
);

  // R7: no grant while any remote request is outstanding
  a_r7_no_grant_pending: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> (rmt_req == '0));

  // R8: no new fault accepted while remote requests are out
  a_r8_busy_while_remote: assert property (@(posedge clk) disable iff (rst)
    (|rmt_req) |-> !flt_ready);

  // R8: grant is a single-cycle pulse
  a_r8_grant_pulse: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |=> !gnt_valid);

  // R2: a downgrade only ever addresses the single writer
  a_r2_downgrade_single: assert property (@(posedge clk) disable iff (rst)
    ((|rmt_req) && rmt_op) |-> ($countones(rmt_req) == 1));

  // R6: a flush only ever addresses the single writer
  a_r6_flush_single: assert property (@(posedge clk) disable iff (rst)
    ((|rmt_req) && rmt_flush) |-> ($countones(rmt_req) == 1));

  // R10: the page of an outstanding request does not move
  a_r10_page_stable: assert property (@(posedge clk) disable iff (rst)
    ((|rmt_req) && (|$past(rmt_req))) |-> $stable(rmt_page));

  // R7: each request bit holds until its acknowledge is seen
  for (genvar i = 0; i < NPROC; i++) begin : g_hold
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
      (rmt_req[i] && !rmt_ack[i]) |=> rmt_req[i]);
  end

endmodule

bind page_coh_dir page_coh_dir_chk #(.NPROC(NPROC), .PW(PW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .flt_ready (flt_ready),
  .rmt_req   (rmt_req),
  .rmt_op    (rmt_op),
  .rmt_flush (rmt_flush),
  .rmt_page  (rmt_page),
  .rmt_ack   (rmt_ack),
  .gnt_valid (gnt_valid)
);

// File: tb/page_coh_dir_tb_top.sv
`timescale 1ns/1ps
module page_coh_dir_tb_top;

  localparam int NPROC = 4;
  localparam int NPAGE = 16;
  localparam int IDW   = 2;
  localparam int PW    = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             flt_valid = 1'b0;
  logic             flt_ready;
  logic             flt_write = 1'b0;
  logic [IDW-1:0]   flt_cpu = '0;
  logic [PW-1:0]    flt_page = '0;
  logic [NPROC-1:0] rmt_req;
  logic             rmt_op;
  logic             rmt_flush;
  logic [PW-1:0]    rmt_page;
  logic [NPROC-1:0] rmt_ack = '0;
  logic             gnt_valid;
  logic [IDW-1:0]   gnt_cpu;
  logic [PW-1:0]    gnt_page;
  logic [1:0]       gnt_prot;

  always #4 clk = ~clk;

  page_coh_dir #(.NPROC(NPROC), .NPAGE(NPAGE), .WB_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst),
    .flt_valid(flt_valid), .flt_ready(flt_ready), .flt_write(flt_write),
    .flt_cpu(flt_cpu), .flt_page(flt_page),
    .rmt_req(rmt_req), .rmt_op(rmt_op), .rmt_flush(rmt_flush),
    .rmt_page(rmt_page), .rmt_ack(rmt_ack),
    .gnt_valid(gnt_valid), .gnt_cpu(gnt_cpu), .gnt_page(gnt_page),
    .gnt_prot(gnt_prot)
  );

  typedef struct {
    int    cpu;
    int    page;
    int    prot;
    int    tgt;
    int    op;
    int    flush;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   dly[NPROC] = '{2, 2, 2, 2};
  int   cnt[NPROC] = '{0, 0, 0, 0};
  bit   seen_rmt = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
      finish_run();
    end
  end

  // monitor, scoreboard and remote responder
  always @(negedge clk) begin
    if (!rst) begin
      if (gnt_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8", "unexpected grant", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(int'(gnt_cpu) == e.cpu, "R10", {e.tag, " gnt_cpu"}, int'(gnt_cpu), e.cpu);
          chk(int'(gnt_page) == e.page, "R10", {e.tag, " gnt_page"}, int'(gnt_page), e.page);
          chk(int'(gnt_prot) == e.prot, e.tag, "gnt_prot", int'(gnt_prot), e.prot);
          chk(rmt_req == '0, "R7", "request still high at grant", int'(rmt_req), 0);
          if (e.tgt != 0) begin
            chk(seen_rmt, "R7", {e.tag, " remote request before grant"}, int'(seen_rmt), 1);
            chk(rmt_ack != '0, "R7", "grant right after last ack", int'(rmt_ack), 1);
          end else begin
            chk(!seen_rmt, "R9", {e.tag, " no remote request"}, int'(seen_rmt), 0);
          end
        end
        seen_rmt = 1'b0;
      end
      if (rmt_req != '0 && !seen_rmt) begin
        seen_rmt = 1'b1;
        if (q.size() != 0) begin
          chk(int'(rmt_req) == q[0].tgt, q[0].tag, "rmt_req", int'(rmt_req), q[0].tgt);
          chk(int'(rmt_op) == q[0].op, q[0].tag, "rmt_op", int'(rmt_op), q[0].op);
          chk(int'(rmt_flush) == q[0].flush, "R6", {q[0].tag, " rmt_flush"},
              int'(rmt_flush), q[0].flush);
          chk(int'(rmt_page) == q[0].page, "R10", "rmt_page", int'(rmt_page), q[0].page);
        end
      end
      for (int i = 0; i < NPROC; i++) begin
        if (rmt_ack[i]) begin
          rmt_ack[i] = 1'b0;
          cnt[i] = 0;
        end else if (rmt_req[i]) begin
          cnt[i]++;
          if (cnt[i] >= dly[i]) rmt_ack[i] = 1'b1;
        end
      end
    end
  end

  task automatic fault(input int cpu, input int page, input bit wr, input int prot,
                       input int tgt, input int op, input int flush, input string tag);
    exp_t e;
    e.cpu = cpu; e.page = page; e.prot = prot; e.tgt = tgt;
    e.op = op; e.flush = flush; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    flt_valid = 1'b1;
    flt_write = wr;
    flt_cpu   = IDW'(cpu);
    flt_page  = PW'(page);
    while (!flt_ready) @(negedge clk);
    @(negedge clk);
    flt_valid = 1'b0;
    chk(!flt_ready, "R8", "ready low after accept", int'(flt_ready), 0);
    while (q.size() != 0) @(negedge clk);
    chk(flt_ready, "R8", "ready back after grant", int'(flt_ready), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!flt_ready, "R1", "ready low during clear", int'(flt_ready), 0);
    chk(rmt_req == '0, "R1", "no request after reset", int'(rmt_req), 0);
    chk(!gnt_valid, "R1", "no grant after reset", int'(gnt_valid), 0);
    while (!flt_ready) @(negedge clk);

    fault(0, 3, 1'b0, 1, 0, 0, 0, "R1");
    fault(1, 3, 1'b0, 1, 0, 0, 0, "R5");
    fault(2, 3, 1'b0, 1, 0, 0, 0, "R5");
    fault(0, 3, 1'b0, 1, 0, 0, 0, "R9");
    // readers 0 and 2 acknowledge in the same cycle
    fault(1, 3, 1'b1, 2, 4'b0101, 0, 0, "R3");
    fault(1, 3, 1'b1, 2, 0, 0, 0, "R9");
    fault(1, 3, 1'b0, 2, 0, 0, 0, "R9");
    fault(3, 3, 1'b0, 1, 4'b0010, 1, 1, "R2");
    fault(1, 3, 1'b0, 1, 0, 0, 0, "R2");
    // staggered acks: processor 3 answers before processor 1
    dly[1] = 5;
    dly[3] = 1;
    fault(0, 3, 1'b1, 2, 4'b1010, 0, 0, "R7");
    dly[1] = 2;
    dly[3] = 2;
    fault(2, 3, 1'b1, 2, 4'b0001, 0, 1, "R4");
    fault(0, 7, 1'b0, 1, 0, 0, 0, "R10");
    fault(0, 7, 1'b1, 2, 0, 0, 0, "R10");
    fault(3, 15, 1'b1, 2, 0, 0, 0, "R10");
    fault(0, 15, 1'b1, 2, 4'b1000, 0, 1, "R6");
    fault(2, 0, 1'b0, 1, 0, 0, 0, "R10");
    fault(2, 3, 1'b0, 2, 0, 0, 0, "R9");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule